// File: doc/BRIEF.md
# Processor Bus Cycle Controller

This block is the bus master of a processor's external bus. It accepts one internal transfer at a time. A transfer carries a cycle kind, an address, write data, byte enables and a lock request. The block turns each transfer into one or two external bus cycles. Each cycle opens with a single-clock address strobe. During that clock the address, byte enables and the four cycle-type outputs appear: memory/IO, data/control, write/read and lock. The block then holds everything stable through wait states until the external system returns ready.

The data path is 32 bits wide. A bus-narrow input, sampled when a transfer is accepted, makes the block treat the bus as 16 bits wide. In that mode a transfer that enables bytes in both halves is split into two back-to-back cycles. The upper half travels on the low 16 lanes during the second cycle, and the two read halves are joined before completion is reported. Write data leaves on `data_out` with `data_oe` as the pad enable. Read data arrives on `data_in` while the pads float. When no transfer is pending, the bus is idle: no strobe is issued and no idle code exists on the type outputs.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, `addr_strobe`, `data_oe` and `rsp_done` are 0 and `req_ready` is 1.
- R2: Every bus cycle starts with `addr_strobe` high for exactly one clock. In that clock the address, byte enables and cycle-type outputs of that cycle are already valid.
- R3: The kind code selects the type outputs (`cyc_mem`,`cyc_data`,`cyc_write`) as follows: 0 interrupt acknowledge 0,0,0; 1 IO read 0,1,0; 2 IO write 0,1,1; 3 memory read 1,1,0; 4 memory write 1,1,1; 5 halt/shutdown 1,0,1. Codes 6 and 7 act as memory read.
- R4: `cyc_lock` equals the request's lock flag, except that it is always 1 for interrupt acknowledge.
- R5: Ready is sampled on each clock edge after the strobe clock. All cycle outputs hold until a sampled ready. `rsp_done` pulses for one clock, in the clock after the last cycle's ready.
- R6: `data_oe` is 1 during write-type cycles (write output 1) and 0 during read-type cycles.
- R7: With bus-narrow low, one cycle is run. `bus_addr` carries address bits [31:2], `bus_be` carries the request's byte enables, `data_out` carries the full write data, and a read returns the full `data_in`.
- R8: With bus-narrow high and enables set in both halves (bits 1:0 and bits 3:2), two cycles run at the same address. The first uses enables {00,be[1:0]} with lanes 15:0 = wdata[15:0]. The second uses {be[3:2],00} with lanes 15:0 = wdata[31:16]. A read returns {second data_in[15:0], first data_in[15:0]}.
- R9: With bus-narrow high and only one half enabled, a single cycle runs. An upper-only transfer moves on lanes 15:0 and its read lands in bits 31:16. The unused half of the read result is 0, and lanes 31:16 of `data_in` are ignored.
- R10: `req_ready` is 0 from acceptance until the transfer completes. No strobe is issued without an accepted request, whatever `bus_ready` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Controller idle; request taken on this edge when valid |
| req_kind | input | 3 | Cycle kind code (R3) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit n for lane byte n |
| req_lock | input | 1 | Request a locked cycle |
| bus_narrow | input | 1 | Treat the bus as 16 bits wide |
| addr_strobe | output | 1 | Cycle start strobe |
| cyc_mem | output | 1 | 1 memory, 0 IO |
| cyc_data | output | 1 | 1 data, 0 control |
| cyc_write | output | 1 | 1 write, 0 read |
| cyc_lock | output | 1 | Locked cycle |
| bus_addr | output | 30 | Doubleword address bits 31:2 |
| bus_be | output | 4 | Byte enables of the current cycle |
| data_out | output | 32 | Data toward the bus pads |
| data_oe | output | 1 | Pad output enable |
| data_in | input | 32 | Data from the bus pads |
| bus_ready | input | 1 | External ready, ends a cycle |
| rsp_done | output | 1 | Transfer complete pulse |
| rsp_rdata | output | 32 | Read result, valid with `rsp_done` |

## Verification
The assertions assume that `bus_ready` carries meaning only in the data phase after a strobe. They also assume that `bus_narrow` and the request fields count only in the clock a request is taken, and that a transfer never has all byte enables clear. The stimulus drives requests only at the idle handshake and raises ready only in data-phase clocks, with zero to three wait states. It also pulses ready during a quiet idle stretch, which exercises the rule that ready alone never starts a cycle.

// File: rtl/bcc_pkg.sv
// Shared types for the bus cycle controller.
// Assumes: kind codes are fixed; the type encodings are decoded in bcc_decode.
package bcc_pkg;
    typedef enum logic [2:0] {
        KIND_INTA = 3'd0,
        KIND_IORD = 3'd1,
        KIND_IOWR = 3'd2,
        KIND_MRD  = 3'd3,
        KIND_MWR  = 3'd4,
        KIND_HALT = 3'd5
    } xfer_kind_e;

    typedef struct packed {
        logic is_mem;
        logic is_data;
        logic is_write;
        logic locked;
    } cyc_def_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bus_st_e;
endpackage

// File: rtl/bcc_decode.sv
// Maps a transfer kind and lock request onto the four cycle-type outputs.
// Assumes: reserved kind codes fall back to memory read; interrupt
// acknowledge forces lock.
module bcc_decode
    import bcc_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       lock_req,
    output cyc_def_t   def
);
    // Purpose: combinational kind-to-type table.
    always_comb begin
        def = '0;
        case (kind)
            KIND_INTA: begin def.is_mem = 1'b0; def.is_data = 1'b0; def.is_write = 1'b0; end
            KIND_IORD: begin def.is_mem = 1'b0; def.is_data = 1'b1; def.is_write = 1'b0; end
            KIND_IOWR: begin def.is_mem = 1'b0; def.is_data = 1'b1; def.is_write = 1'b1; end
            KIND_MWR:  begin def.is_mem = 1'b1; def.is_data = 1'b1; def.is_write = 1'b1; end
            KIND_HALT: begin def.is_mem = 1'b1; def.is_data = 1'b0; def.is_write = 1'b1; end
            default:   begin def.is_mem = 1'b1; def.is_data = 1'b1; def.is_write = 1'b0; end
        endcase
        def.locked = lock_req || (kind == KIND_INTA);
    end
endmodule

// File: rtl/bcc_lane.sv
// Lane steering for the write path and byte enables of the current cycle.
// Assumes: in narrow mode only the low half of the lanes carries data, so
// an upper-half cycle copies the upper write data down onto them.
module bcc_lane #(
    parameter  int DATA_W = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int HBE_W  = BE_W / 2
) (
    input  logic              narrow,
    input  logic              upper_seg,
    input  logic [BE_W-1:0]   be_full,
    input  logic [DATA_W-1:0] wdata,
    output logic [BE_W-1:0]   seg_be,
    output logic [DATA_W-1:0] seg_wdata
);
    // Purpose: choose enables and lane data for the half being transferred.
    always_comb begin
        if (!narrow) begin
            seg_be    = be_full;
            seg_wdata = wdata;
        end else if (upper_seg) begin
            seg_be    = {be_full[BE_W-1:HBE_W], {HBE_W{1'b0}}};
            seg_wdata = {wdata[DATA_W-1:HALF_W], wdata[DATA_W-1:HALF_W]};
        end else begin
            seg_be    = {{HBE_W{1'b0}}, be_full[HBE_W-1:0]};
            seg_wdata = wdata;
        end
    end
endmodule

// File: rtl/bcc_rdasm.sv
// Read data assembly: collects the full bus or one 16-bit half per cycle.
// Assumes: clear arrives on acceptance, capture on the ready edge of a
// read cycle; halves not transferred stay zero.
module bcc_rdasm #(
    parameter  int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              narrow,
    input  logic              upper_seg,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] rdata
);
    // Purpose: register the read result, one half at a time in narrow mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (clear) begin
            rdata <= '0;
        end else if (capture) begin
            if (!narrow)
                rdata <= data_in;
            else if (upper_seg)
                rdata[DATA_W-1:HALF_W] <= data_in[HALF_W-1:0];
            else
                rdata[HALF_W-1:0] <= data_in[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/bcc_seq.sv
// Cycle sequencer: idle, address (strobe) and data (wait) phases, with an
// optional second pass for a split transfer and a one-clock done pulse.
// Assumes: ready is only meaningful in the data phase.
module bcc_seq
    import bcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_split,
    input  logic bus_ready,
    output logic req_ready,
    output logic accept,
    output logic strobe,
    output logic busy,
    output logic second_half,
    output logic seg_end,
    output logic done
);
    bus_st_e state;
    logic    split_q;

    // Purpose: handshake and phase decode from the state register.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        strobe    = (state == ST_ADDR);
        busy      = (state != ST_IDLE);
        seg_end   = (state == ST_DATA) && bus_ready;
    end

    // Purpose: advance phases, track split halves and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            split_q     <= 1'b0;
            second_half <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state       <= ST_ADDR;
                        split_q     <= req_split;
                        second_half <= 1'b0;
                    end
                end
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (bus_ready) begin
                        if (split_q && !second_half) begin
                            state       <= ST_ADDR;
                            second_half <= 1'b1;
                        end else begin
                            state       <= ST_IDLE;
                            second_half <= 1'b0;
                            done        <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R2
    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_ready)); // R5
endmodule

// File: rtl/bus_cycle_ctrl.sv
// Top of the bus cycle controller. Latches a transfer on acceptance, decodes
// its cycle type, steers lanes for 32- or 16-bit operation and returns the
// assembled read data with a done pulse.
// Assumes: request fields and bus_narrow are sampled only on acceptance;
// a transfer enables at least one byte.
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int HBE_W  = BE_W / 2,
    localparam int WA_LSB = $clog2(BE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_lock,
    input  logic              bus_narrow,
    output logic              addr_strobe,
    output logic              cyc_mem,
    output logic              cyc_data,
    output logic              cyc_write,
    output logic              cyc_lock,
    output logic [ADDR_W-WA_LSB-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_in,
    input  logic              bus_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);
    cyc_def_t                 def_new, def_q;
    logic [ADDR_W-WA_LSB-1:0] addr_q;
    logic [DATA_W-1:0]        wdata_q;
    logic [BE_W-1:0]          be_q;
    logic                     narrow_q, upper_only_q;
    logic                     req_split, req_upper_only;
    logic                     accept, busy, second_half, seg_end, upper_seg;

    // Purpose: classify the incoming transfer for narrow-bus handling.
    always_comb begin
        req_split      = bus_narrow && (|req_be[HBE_W-1:0]) && (|req_be[BE_W-1:HBE_W]);
        req_upper_only = bus_narrow && !(|req_be[HBE_W-1:0]) && (|req_be[BE_W-1:HBE_W]);
    end

    bcc_decode u_decode (
        .kind     (req_kind),
        .lock_req (req_lock),
        .def      (def_new)
    );

    bcc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_split   (req_split),
        .bus_ready   (bus_ready),
        .req_ready   (req_ready),
        .accept      (accept),
        .strobe      (addr_strobe),
        .busy        (busy),
        .second_half (second_half),
        .seg_end     (seg_end),
        .done        (rsp_done)
    );

    // Purpose: hold the accepted transfer for the whole bus operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            def_q        <= '0;
            addr_q       <= '0;
            wdata_q      <= '0;
            be_q         <= '0;
            narrow_q     <= 1'b0;
            upper_only_q <= 1'b0;
        end else if (accept) begin
            def_q        <= def_new;
            addr_q       <= req_addr[ADDR_W-1:WA_LSB];
            wdata_q      <= req_wdata;
            be_q         <= req_be;
            narrow_q     <= bus_narrow;
            upper_only_q <= req_upper_only;
        end
    end

    assign upper_seg = upper_only_q || second_half;

    bcc_lane #(.DATA_W(DATA_W)) u_lane (
        .narrow    (narrow_q),
        .upper_seg (upper_seg),
        .be_full   (be_q),
        .wdata     (wdata_q),
        .seg_be    (bus_be),
        .seg_wdata (data_out)
    );

    bcc_rdasm #(.DATA_W(DATA_W)) u_rdasm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (seg_end && !def_q.is_write),
        .narrow    (narrow_q),
        .upper_seg (upper_seg),
        .data_in   (data_in),
        .rdata     (rsp_rdata)
    );

    // Purpose: drive the cycle-definition outputs and pad enable.
    always_comb begin
        cyc_mem   = def_q.is_mem;
        cyc_data  = def_q.is_data;
        cyc_write = def_q.is_write;
        cyc_lock  = def_q.locked;
        bus_addr  = addr_q;
        data_oe   = busy && def_q.is_write;
    end

    AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !addr_strobe && !bus_ready) |=>
        $stable({bus_addr, bus_be, cyc_mem, cyc_data, cyc_write, cyc_lock, data_out, data_oe})); // R5
    AST_INTA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && !cyc_mem && !cyc_data && !cyc_write) |-> cyc_lock); // R4
    AST_NARROW_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && narrow_q) |-> ((bus_be[BE_W-1:HBE_W] == '0) || (bus_be[HBE_W-1:0] == '0))); // R8
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && !addr_strobe)); // R10
endmodule

// File: tb/tb_bus_cycle_ctrl.sv
// Scoreboard bench: the driver task queues expected bus cycles and results,
// a monitor pops and compares them as the controller produces them.
`timescale 1ns/1ps
module tb_bus_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_lock = 1'b0;
    logic        bus_narrow = 1'b0;
    logic        addr_strobe, cyc_mem, cyc_data, cyc_write, cyc_lock;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] data_out;
    logic        data_oe;
    logic [31:0] data_in = '0;
    logic        bus_ready = 1'b0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int xfers  = 0;
    int dones  = 0;
    int strobes = 0;

    typedef struct {
        logic [29:0] addr;
        logic [3:0]  be;
        logic [2:0]  def;
        logic        lock;
        logic        wr;
        logic        full;
        logic [31:0] wd;
        logic        narrow;
    } exp_cyc_t;
    typedef struct {
        logic        chk;
        logic [31:0] rd;
        logic        narrow;
    } exp_rsp_t;

    exp_cyc_t cyc_q[$];
    exp_rsp_t rsp_q[$];

    bus_cycle_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .req_lock(req_lock), .bus_narrow(bus_narrow),
        .addr_strobe(addr_strobe), .cyc_mem(cyc_mem), .cyc_data(cyc_data),
        .cyc_write(cyc_write), .cyc_lock(cyc_lock), .bus_addr(bus_addr),
        .bus_be(bus_be), .data_out(data_out), .data_oe(data_oe),
        .data_in(data_in), .bus_ready(bus_ready), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected type outputs {mem,data,write} per the R3 table.
    function automatic logic [2:0] exp_def(input logic [2:0] k);
        case (k)
            3'd0: return 3'b000;
            3'd1: return 3'b010;
            3'd2: return 3'b011;
            3'd4: return 3'b111;
            3'd5: return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    // Driver: queue expectations, then run the request and the bus side.
    task automatic xfer(input logic [2:0] k, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input logic lk, input logic nar,
                        input int waits, input logic [31:0] rd);
        logic [2:0] d;
        logic       split, uponly;
        exp_cyc_t   c;
        exp_rsp_t   r;
        int         nseg;
        logic [31:0] seg_in [2];
        d      = exp_def(k);
        split  = nar && (|be[1:0]) && (|be[3:2]);
        uponly = nar && !(|be[1:0]) && (|be[3:2]);
        c.addr = a[31:2]; c.def = d; c.lock = lk || (k == 3'd0); c.wr = d[0];
        c.narrow = nar;
        if (!nar) begin
            c.be = be; c.full = 1'b1; c.wd = wd; cyc_q.push_back(c);
            seg_in[0] = rd; nseg = 1; r.rd = rd;
        end else if (split) begin
            c.full = 1'b0;
            c.be = {2'b00, be[1:0]}; c.wd = {16'h0, wd[15:0]};  cyc_q.push_back(c);
            c.be = {be[3:2], 2'b00}; c.wd = {16'h0, wd[31:16]}; cyc_q.push_back(c);
            seg_in[0] = {16'hA5A5, rd[15:0]}; seg_in[1] = {16'h5A5A, rd[31:16]};
            nseg = 2; r.rd = rd;
        end else if (uponly) begin
            c.full = 1'b0; c.be = {be[3:2], 2'b00}; c.wd = {16'h0, wd[31:16]}; cyc_q.push_back(c);
            seg_in[0] = {16'hC3C3, rd[31:16]}; nseg = 1; r.rd = {rd[31:16], 16'h0};
        end else begin
            c.full = 1'b0; c.be = {2'b00, be[1:0]}; c.wd = {16'h0, wd[15:0]}; cyc_q.push_back(c);
            seg_in[0] = {16'h3C3C, rd[15:0]}; nseg = 1; r.rd = {16'h0, rd[15:0]};
        end
        r.chk = !d[0]; r.narrow = nar;
        rsp_q.push_back(r);
        xfers++;
        @(negedge clk);
        req_kind = k; req_addr = a; req_wdata = wd; req_be = be; req_lock = lk;
        bus_narrow = nar; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; bus_narrow = 1'b0; req_wdata = 32'hFFFF_FFFF;
        for (int s = 0; s < nseg; s++) begin
            @(negedge clk);
            for (int w = 0; w < waits; w++) begin
                data_in = 32'hDEAD_BEEF;
                @(negedge clk);
            end
            bus_ready = 1'b1; data_in = seg_in[s];
            @(negedge clk);
            bus_ready = 1'b0; data_in = 32'h0BAD_F00D;
        end
    endtask

    // Monitor: compare strobes, held outputs and results with the queues.
    exp_cyc_t cur;
    logic     have_cur = 1'b0;
    logic     prev_strobe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_strobe) begin
                strobes++;
                check(!prev_strobe, "R2 strobe longer than one clock", 32'(prev_strobe), 32'd0);
                check(!req_ready, "R10 ready while busy", 32'(req_ready), 32'd0);
                if (cyc_q.size() == 0) begin
                    check(1'b0, "R10 strobe without request", 32'd1, 32'd0);
                    have_cur = 1'b0;
                end else begin
                    cur = cyc_q.pop_front();
                    have_cur = 1'b1;
                    check({cyc_mem, cyc_data, cyc_write} == cur.def, "R3 type outputs",
                          32'({cyc_mem, cyc_data, cyc_write}), 32'(cur.def));
                    check(cyc_lock == cur.lock, "R4 lock", 32'(cyc_lock), 32'(cur.lock));
                    check(data_oe == cur.wr, "R6 data_oe", 32'(data_oe), 32'(cur.wr));
                    check(bus_addr == cur.addr, cur.narrow ? "R8 address" : "R7 address",
                          32'(bus_addr), 32'(cur.addr));
                    check(bus_be == cur.be, cur.narrow ? "R8/R9 byte enables" : "R7 byte enables",
                          32'(bus_be), 32'(cur.be));
                    if (cur.wr && cur.full)
                        check(data_out == cur.wd, "R7 write data", data_out, cur.wd);
                    else if (cur.wr)
                        check(data_out[15:0] == cur.wd[15:0], "R8/R9 low-lane write data",
                              32'(data_out[15:0]), cur.wd);
                end
            end else if (!req_ready && have_cur) begin
                check(bus_addr == cur.addr && bus_be == cur.be &&
                      {cyc_mem, cyc_data, cyc_write} == cur.def && data_oe == cur.wr,
                      "R5 outputs held in data phase", 32'(bus_be), 32'(cur.be));
            end
            if (rsp_done) begin
                dones++;
                if (rsp_q.size() == 0) begin
                    check(1'b0, "R5 done without transfer", 32'd1, 32'd0);
                end else begin
                    exp_rsp_t r;
                    r = rsp_q.pop_front();
                    if (r.chk)
                        check(rsp_rdata == r.rd, r.narrow ? "R8/R9 read data" : "R7 read data",
                              rsp_rdata, r.rd);
                end
            end
        end
        prev_strobe = addr_strobe;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        // R1: reset state while held.
        check(!addr_strobe && !data_oe && !rsp_done && req_ready, "R1 reset outputs",
              {28'd0, addr_strobe, data_oe, rsp_done, req_ready}, 32'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!addr_strobe && !data_oe && !rsp_done && req_ready, "R1 idle after reset",
              {28'd0, addr_strobe, data_oe, rsp_done, req_ready}, 32'h1);

        // 32-bit cycles of every kind (R3, R4, R6, R7), varied waits (R5).
        xfer(3'd3, 32'h1000_0004, 32'h0, 4'hF, 1'b0, 1'b0, 0, 32'h1234_5678);
        xfer(3'd4, 32'h2000_0008, 32'hCAFE_F00D, 4'hF, 1'b0, 1'b0, 2, 32'h0);
        xfer(3'd1, 32'h0000_0060, 32'h0, 4'h1, 1'b0, 1'b0, 1, 32'h0000_00AB);
        xfer(3'd2, 32'h0000_0064, 32'h0000_5500, 4'h2, 1'b0, 1'b0, 3, 32'h0);
        xfer(3'd0, 32'h0000_0000, 32'h0, 4'h1, 1'b0, 1'b0, 1, 32'h0000_0021);
        xfer(3'd5, 32'h0000_0002, 32'h0, 4'h4, 1'b0, 1'b0, 0, 32'h0);
        xfer(3'd3, 32'h3000_0010, 32'h0, 4'hF, 1'b1, 1'b0, 1, 32'h8765_4321);
        xfer(3'd4, 32'h3000_0010, 32'h0102_0304, 4'h6, 1'b1, 1'b0, 0, 32'h0);
        xfer(3'd7, 32'h4000_0000, 32'h0, 4'hF, 1'b0, 1'b0, 0, 32'hFEDC_BA98);
        // Narrow bus: split transfers (R8) and single-half transfers (R9).
        xfer(3'd3, 32'h5000_0020, 32'h0, 4'hF, 1'b0, 1'b1, 0, 32'hAABB_CCDD);
        xfer(3'd4, 32'h5000_0024, 32'h1122_3344, 4'hF, 1'b0, 1'b1, 2, 32'h0);
        xfer(3'd3, 32'h5000_0028, 32'h0, 4'h6, 1'b1, 1'b1, 1, 32'h7788_9900);
        xfer(3'd3, 32'h6000_0000, 32'h0, 4'hC, 1'b0, 1'b1, 1, 32'hBEEF_0000);
        xfer(3'd4, 32'h6000_0004, 32'h9988_7766, 4'h8, 1'b0, 1'b1, 0, 32'h0);
        xfer(3'd1, 32'h0000_0070, 32'h0, 4'h3, 1'b0, 1'b1, 2, 32'hFFFF_1357);

        // R10: quiet bus with ready pulses must not start a cycle.
        s0 = strobes;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_ready = i[0];
        end
        @(negedge clk);
        bus_ready = 1'b0;
        repeat (2) @(negedge clk);
        check(strobes == s0, "R10 no strobe while idle", 32'(strobes), 32'(s0));
        check(req_ready && !data_oe, "R10 idle after transfers", 32'(req_ready), 32'd1);
        check(dones == xfers, "R5 one done per transfer", 32'(dones), 32'(xfers));
        check(cyc_q.size() == 0 && rsp_q.size() == 0, "R8 all expected cycles seen",
              32'(cyc_q.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule